// File: doc/BRIEF.md
# Longest Prefix Match Associative Table

The block is a small associative forwarding table. Each slot keeps a 32-bit address, a prefix mask and a valid bit. When a search starts, the key is compared with every valid slot at once, and the result is one hit bit per slot. Only the slots that hit go on to the next stage. That stage resolves the longest prefix by walking mask bit positions. It starts at the least significant position and checks one position per clock. At each position it asks whether any surviving slot has a 1 there. The first position that answers yes holds the longest prefix.

Software manages the free slots. It writes a slot at any index and deletes a slot by index, and neither operation needs sorting or pre-computation. A write or delete that arrives while a search is running does not disturb that search. The next-hop memory addressed by the winning index is outside the block.

Top module: `lpm_table`

## Requirements
- R1: A slot takes part in a search only if it is valid and (key AND mask) equals (address AND mask) on all 32 bits.
- R2: Masks are contiguous ones from bit 31. Among the slots taking part, the winner is a slot with the most ones in its mask.
- R3: A search started at clock edge E with a longest matching prefix of length L (1 to 32) raises `done` for one cycle after edge E+33-L. It reports `hit`=1 and `slices`=33-L.
- R4: A zero-length prefix (mask 0) matches every key and wins only when no longer prefix matches. It then reports `hit`=1 and `slices`=32, with `done` after edge E+32.
- R5: When no slot takes part, `done` rises after edge E itself, with `hit`=0 and `slices`=0.
- R6: When several taking-part slots share the winning prefix length, the lowest index wins.
- R7: A write stores address and mask at the given index and marks it valid, whatever its position relative to other prefixes. A write to a used index replaces the old contents.
- R8: A delete clears the valid bit of the given index, so that slot no longer matches any key.
- R9: A write or delete presented while `busy` is high does not change the running search. The most recent such operation is applied at the edge that issues `done`.
- R10: `busy` is high from the edge that starts a search with at least one participating slot until the edge that issues `done`. It is low while `done` is high. `start` while `busy` is ignored.
- R11: After reset all slots are invalid and `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write a slot |
| wr_idx | input | IW | Index written or deleted |
| wr_addr | input | 32 | Address to store |
| wr_mask | input | 32 | Prefix mask to store |
| del_en | input | 1 | Invalidate slot `wr_idx` (write wins if both) |
| start | input | 1 | Begin a search when not busy |
| key | input | 32 | Search key, sampled with `start` |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | A slot matched |
| win_idx | output | IW | Winning slot index |
| slices | output | 6 | Mask positions walked |

## Verification
The bench builds the table with DEPTH=8. At that size every slot can be filled, including an empty slot and a duplicate prefix. Prefix lengths 0, 8, 12, 16, 24 and 32 are loaded in scrambled slot order, so the latency runs over its whole range from 0 to 32 slices. That range includes the default-route fallback on the last slice. The bench measures the latency by counting clock edges and compares it with the reported slice count.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int unsigned KEY_W = 32;
    localparam int unsigned SLC_W = $clog2(KEY_W + 1);
    localparam int unsigned POS_W = $clog2(KEY_W);

    typedef enum logic [0:0] {ST_IDLE, ST_SCAN} lpm_state_e;
    typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_DEL} lpm_op_e;

    typedef struct packed {
        logic             valid;
        logic [KEY_W-1:0] addr;
        logic [KEY_W-1:0] mask;
    } lpm_slot_t;
endpackage

// File: rtl/lpm_entry.sv
module lpm_entry
    import lpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             de,
    input  logic [KEY_W-1:0] d_addr,
    input  logic [KEY_W-1:0] d_mask,
    input  logic [KEY_W-1:0] key,
    output logic             match,
    output logic [KEY_W-1:0] mask_q
);
    lpm_slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (we) begin
            slot_q <= '{valid: 1'b1, addr: d_addr, mask: d_mask};
        end else if (de) begin
            slot_q.valid <= 1'b0;
        end
    end

    assign match  = slot_q.valid && (((key ^ slot_q.addr) & slot_q.mask) == '0);
    assign mask_q = slot_q.mask;

    // R8: a delete leaves the slot unable to match
    a_r8_delete_clears: assert property (@(posedge clk) disable iff (rst)
        (de && !we) |=> !match);
    // R7: written mask is what the slot exposes next cycle
    a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (mask_q == $past(d_mask)));
endmodule

// File: rtl/lpm_slice_pick.sv
module lpm_slice_pick #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned IW    = 4
) (
    input  logic [DEPTH-1:0] en,
    input  logic [DEPTH-1:0] col,
    output logic             fb,
    output logic [IW-1:0]    col_idx,
    output logic [IW-1:0]    any_idx
);
    logic [DEPTH-1:0] live;
    assign live = en & col;
    assign fb   = |live;

    always_comb begin
        col_idx = '0;
        any_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (live[i]) col_idx = IW'(i);
            if (en[i])   any_idx = IW'(i);
        end
    end
endmodule

// File: rtl/lpm_table.sv
module lpm_table
    import lpm_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [KEY_W-1:0] wr_addr,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic             del_en,
    input  logic             start,
    input  logic [KEY_W-1:0] key,
    output logic             busy,
    output logic             done,
    output logic             hit,
    output logic [IW-1:0]    win_idx,
    output logic [SLC_W-1:0] slices
);
    lpm_state_e       state_q;
    logic [DEPTH-1:0] match, en_q, col;
    logic [KEY_W-1:0] mask_q [DEPTH];
    logic [POS_W-1:0] pos_q;
    logic             fb, last, idle, finish;
    logic [IW-1:0]    col_idx, any_idx;

    lpm_op_e          in_op, pend_op, app_op;
    logic [IW-1:0]    pend_idx, app_idx;
    logic [KEY_W-1:0] pend_addr, pend_mask, app_addr, app_mask;

    assign idle   = (state_q == ST_IDLE);
    assign busy   = (state_q == ST_SCAN);
    assign last   = (pos_q == POS_W'(KEY_W - 1));
    assign finish = busy && (fb || last);
    assign in_op  = wr_en ? OP_WRITE : (del_en ? OP_DEL : OP_NONE);

    // table updates: direct when idle, deferred to the finishing edge when busy
    always_comb begin
        app_op   = OP_NONE;
        app_idx  = wr_idx;
        app_addr = wr_addr;
        app_mask = wr_mask;
        if ((idle || finish) && in_op != OP_NONE) begin
            app_op = in_op;
        end else if (finish) begin
            app_op   = pend_op;
            app_idx  = pend_idx;
            app_addr = pend_addr;
            app_mask = pend_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_op   <= OP_NONE;
            pend_idx  <= '0;
            pend_addr <= '0;
            pend_mask <= '0;
        end else if (finish) begin
            pend_op <= OP_NONE;
        end else if (busy && in_op != OP_NONE) begin
            pend_op   <= in_op;
            pend_idx  <= wr_idx;
            pend_addr <= wr_addr;
            pend_mask <= wr_mask;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        lpm_entry u_entry (
            .clk    (clk),
            .rst    (rst),
            .we     (app_op == OP_WRITE && app_idx == IW'(i)),
            .de     (app_op == OP_DEL && app_idx == IW'(i)),
            .d_addr (app_addr),
            .d_mask (app_mask),
            .key    (key),
            .match  (match[i]),
            .mask_q (mask_q[i])
        );
        assign col[i] = mask_q[i][pos_q];
    end

    lpm_slice_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
        .en      (en_q),
        .col     (col),
        .fb      (fb),
        .col_idx (col_idx),
        .any_idx (any_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            en_q    <= '0;
            pos_q   <= '0;
            done    <= 1'b0;
            hit     <= 1'b0;
            win_idx <= '0;
            slices  <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    en_q  <= match;
                    pos_q <= '0;
                    if (|match) begin
                        state_q <= ST_SCAN;
                    end else begin
                        done    <= 1'b1;
                        hit     <= 1'b0;
                        win_idx <= '0;
                        slices  <= '0;
                    end
                end
                ST_SCAN: if (finish) begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                    hit     <= 1'b1;
                    win_idx <= fb ? col_idx : any_idx;
                    slices  <= SLC_W'(pos_q) + SLC_W'(1);
                end else begin
                    pos_q <= pos_q + POS_W'(1);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5: result strobe lasts one cycle
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R5: a miss reports zero slices
    a_r5_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (done && !hit) |-> (slices == '0));
    // R3: a hit reports between 1 and KEY_W slices
    a_r3_slices_range: assert property (@(posedge clk) disable iff (rst)
        (done && hit) |-> (slices >= SLC_W'(1) && slices <= SLC_W'(KEY_W)));
    // R10: busy and done never overlap
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R9: participating set is frozen for the whole walk
    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(en_q));
    // R2: the winner is one of the participating slots
    a_r2_winner_enabled: assert property (@(posedge clk) disable iff (rst)
        (done && hit) |-> en_q[win_idx]);
endmodule

// File: tb/test_lpm_table.sv
module test_lpm_table;
    import lpm_pkg::*;

    localparam int unsigned DEPTH = 8;
    localparam int unsigned IW    = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0, del_en = 1'b0, start = 1'b0;
    logic [IW-1:0]    wr_idx = '0;
    logic [KEY_W-1:0] wr_addr = '0, wr_mask = '0, key = '0;
    logic             busy, done, hit;
    logic [IW-1:0]    win_idx;
    logic [SLC_W-1:0] slices;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    lpm_table #(.DEPTH(DEPTH)) i_lpm_table (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_addr(wr_addr), .wr_mask(wr_mask), .del_en(del_en),
        .start(start), .key(key), .busy(busy), .done(done), .hit(hit),
        .win_idx(win_idx), .slices(slices)
    );

    typedef struct packed {
        logic [31:0] k;
        logic        h;
        logic [2:0]  ix;
        logic [5:0]  sl;
    } vec_t;

    // key, expected hit, index, slices
    localparam vec_t VECS [7] = '{
        '{32'h0A01_0203, 1'b1, 3'd2, 6'd9},   // R2 /24 beats /16 and /8
        '{32'h0A01_0909, 1'b1, 3'd1, 6'd17},  // R6 duplicate /16 at 1 and 5
        '{32'h0AC8_0001, 1'b1, 3'd0, 6'd25},  // R3 /8
        '{32'hC0A8_0101, 1'b1, 3'd4, 6'd1},   // R3 /32 first slice
        '{32'hC0A8_0102, 1'b1, 3'd3, 6'd32},  // R4 default route
        '{32'hAC1F_0001, 1'b1, 3'd6, 6'd21},  // R1 /12 upper edge
        '{32'hAC20_0001, 1'b1, 3'd3, 6'd32}   // R4 just outside /12
    };

    function automatic logic [31:0] pmask(input int len);
        return (len == 0) ? 32'h0 : (32'hFFFF_FFFF << (32 - len));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put(input int idx, input logic [31:0] a, input int len);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_addr = a; wr_mask = pmask(len);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drop(input int idx);
        @(negedge clk);
        del_en = 1'b1; wr_idx = IW'(idx);
        @(negedge clk);
        del_en = 1'b0;
    endtask

    // mid: 0 none, 1 delete slot 2 mid-search, 2 extra start mid-search
    task automatic search(input logic [31:0] k, input bit eh, input int ei,
                          input int es, input int mid, input string tag);
        int n = 0;
        @(negedge clk);
        start = 1'b1; key = k;
        @(negedge clk);
        start = 1'b0;
        if (es > 0) chk(busy == 1'b1, {tag, " busy"}, int'(busy), 1);
        if (mid == 1) begin del_en = 1'b1; wr_idx = 3'd2; end
        if (mid == 2) begin start = 1'b1; key = 32'hC0A8_0101; end
        while (!done && n < 40) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            del_en = 1'b0;
            start  = 1'b0;
        end
        chk(done == 1'b1, {tag, " done"}, int'(done), 1);
        chk(busy == 1'b0, {tag, " busy at done"}, int'(busy), 0);
        chk(hit == eh, {tag, " hit"}, int'(hit), int'(eh));
        if (eh) chk(int'(win_idx) == ei, {tag, " idx"}, int'(win_idx), ei);
        chk(int'(slices) == es, {tag, " slices"}, int'(slices), es);
        if (mid == 0) chk(n == es, {tag, " latency"}, n, es);
        @(negedge clk);
        chk(done == 1'b0, {tag, " pulse"}, int'(done), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state and empty table
        chk(done == 1'b0, "R11 done", int'(done), 0);
        chk(busy == 1'b0, "R11 busy", int'(busy), 0);
        search(32'h0A01_0203, 1'b0, 0, 0, 0, "R11 empty table");

        // R7 unsorted placement
        put(4, 32'hC0A8_0101, 32);
        put(0, 32'h0A00_0000, 8);
        put(5, 32'h0A01_0000, 16);
        put(2, 32'h0A01_0200, 24);
        put(3, 32'h0000_0000, 0);
        put(6, 32'hAC10_0000, 12);
        put(1, 32'h0A01_0000, 16);

        foreach (VECS[i])
            search(VECS[i].k, VECS[i].h, int'(VECS[i].ix), int'(VECS[i].sl), 0,
                   $sformatf("R2 R3 vec%0d", i));

        // R9 delete during search does not disturb it, applied afterwards
        search(32'h0A01_0203, 1'b1, 2, 9, 1, "R9 during");
        search(32'h0A01_0203, 1'b1, 1, 17, 0, "R9 after");

        // R10 start during busy ignored
        search(32'h0A01_0203, 1'b1, 1, 17, 2, "R10 extra start");
        repeat (3) begin
            @(negedge clk);
            chk(done == 1'b0 && busy == 1'b0, "R10 no second search",
                int'(done) + int'(busy), 0);
        end

        // R8 R5 delete default route, then miss
        drop(3);
        search(32'hC0A8_0102, 1'b0, 0, 0, 0, "R8 R5 miss");

        // R7 overwrite a used slot
        put(4, 32'hC0A8_0100, 24);
        search(32'hC0A8_0102, 1'b1, 4, 9, 0, "R7 overwrite");
        search(32'hC0A8_0101, 1'b1, 4, 9, 0, "R7 old /32 gone");

        // R7 R1 last free slot
        put(7, 32'h0A01_0200, 24);
        search(32'h0A01_0203, 1'b1, 7, 9, 0, "R7 slot7");
        search(32'h0B01_0203, 1'b0, 0, 0, 0, "R1 no match");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule